// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block sits beside the privileged state of a processor core. When the core raises a trap strobe with a cause word, it works out where that trap lands and what the next architectural state is. The trap can land in supervisor mode, in machine mode, in debug mode on a software breakpoint, or at the debug exception address while debug mode is already active. From that it produces one-cycle write strobes and new values for the PC, privilege, status, cause, exception PC, bad-address, debug control and debug PC registers, plus a strobe that drops any load reservation. The surrounding register file applies those writes.

The cause word carries the interrupt flag in its top bit and the cause code below it. Two delegation masks decide whether a trap taken from a low privilege goes to supervisor mode instead of machine mode: one mask for interrupts and one for exceptions. A per-privilege enable vector diverts breakpoint exceptions into debug mode. Every decision is made combinationally from the inputs present with the trap strobe. All results are registered and appear on the outputs in the cycle after the strobe.

Top module: `trap_unit`

## Requirements
- R1: Every write strobe is high for exactly the one cycle that follows a cycle with `trap_valid` high, and is low in every other cycle. While `rst` is high, all strobes are low.
- R2: If `trap_cause[XLEN-1]` is 1 (interrupt), the delegation bit is read from `mideleg`. If it is 0 (exception), the bit is read from `medeleg`. In both cases the index is the cause code `trap_cause[XLEN-2:0]`.
- R3: Privilege is encoded U=0, S=1, H=2, M=3. A trap goes to supervisor only when `cur_priv` is at most 1, the cause code is below XLEN, and the selected delegation bit is 1. Any other trap that is not diverted to debug goes to machine mode.
- R4: On supervisor entry, `pc_next` is `stvec` and `priv_next` is 1. The strobes for supervisor cause, supervisor EPC, status, PC, privilege and reservation clear are high, with `cause_next` equal to the full cause and `epc_next` equal to `trap_pc`.
- R5: Status layout: bit p (p=0..3) is the interrupt enable of privilege p, bit 5 is SPIE, bit 7 is MPIE, bit 8 is SPP, and bits 12:11 are MPP. On supervisor entry, SPIE takes the enable bit of the old privilege, SPP takes bit 0 of the old privilege, and bit 1 is cleared. All other bits are unchanged.
- R6: On machine entry, `pc_next` is `mtvec` and `priv_next` is 3. The machine cause, machine EPC, status, PC, privilege and reservation-clear strobes are high. In the status word, MPIE takes the old privilege's enable bit, MPP takes the old privilege, and bit 3 is cleared. All other bits are unchanged.
- R7: The bad-address strobe of the target mode (supervisor or machine) is high only when `trap_has_addr` is 1, and `bad_next` then equals `trap_badaddr`. Debug entry and debug exception write no bad address.
- R8: An exception with cause code 3 (breakpoint) taken while `ebreak_en[cur_priv]` is 1 enters debug mode. This happens even when `dbg_cause_in` is nonzero. `pc_next` becomes DBG_ROM_START and `priv_next` becomes 3. The debug control strobe is high with `dbg_cause_next` = 1 and `dbg_prv_next` equal to the old privilege. The debug PC strobe is high with `epc_next` = `trap_pc`. No status or cause strobe is high.
- R9: Any other trap taken while `dbg_cause_in` is nonzero raises only `pc_we`, with `pc_next` = DBG_ROM_EXC.
- R10: `resv_clear` is high only for traps that enter supervisor or machine mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | A trap is signalled this cycle |
| trap_cause | input | XLEN | Interrupt flag in the top bit, cause code below |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_badaddr | input | XLEN | Faulting address |
| trap_has_addr | input | 1 | The cause carries a faulting address |
| cur_priv | input | 2 | Current privilege |
| medeleg | input | XLEN | Exception delegation mask |
| mideleg | input | XLEN | Interrupt delegation mask |
| stvec | input | XLEN | Supervisor trap vector |
| mtvec | input | XLEN | Machine trap vector |
| status_in | input | 13 | Current status bits |
| dbg_cause_in | input | 3 | Current debug cause, nonzero while in debug mode |
| ebreak_en | input | 4 | Per-privilege breakpoint-to-debug enable |
| pc_we | output | 1 | PC write strobe |
| pc_next | output | XLEN | New PC |
| priv_we | output | 1 | Privilege write strobe |
| priv_next | output | 2 | New privilege |
| status_we | output | 1 | Status write strobe |
| status_next | output | 13 | New status bits |
| scause_we | output | 1 | Supervisor cause write |
| sepc_we | output | 1 | Supervisor EPC write |
| sbad_we | output | 1 | Supervisor bad-address write |
| mcause_we | output | 1 | Machine cause write |
| mepc_we | output | 1 | Machine EPC write |
| mbad_we | output | 1 | Machine bad-address write |
| cause_next | output | XLEN | Cause value for the cause write |
| epc_next | output | XLEN | Saved PC for EPC or debug PC write |
| bad_next | output | XLEN | Bad address value |
| dbg_we | output | 1 | Debug control write strobe |
| dbg_cause_next | output | 3 | New debug cause |
| dbg_prv_next | output | 2 | Privilege saved into debug control |
| dpc_we | output | 1 | Debug PC write strobe |
| resv_clear | output | 1 | Drop the load reservation |

## Verification
Two rules can apply to the same trap. A breakpoint can meet an enabled debug-entry bit while the debug cause is already nonzero, so debug entry and the debug-exception redirect both match. An interrupt can carry the same code as a breakpoint while breakpoint entry is enabled. Both cases are table vectors. They are judged by the debug strobes, PC and privilege: the first must enter debug, the second must go to machine mode. Delegation is tested on both sides: codes whose bit is set in only one of the two masks, and a code of 33 whose low bits alias a set delegation bit but which must still go to machine mode.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int ST_W      = 13;
    localparam int ST_SPIE   = 5;
    localparam int ST_MPIE   = 7;
    localparam int ST_SPP    = 8;
    localparam int ST_MPP_LO = 11;
    localparam int ST_SIE    = 1;
    localparam int ST_MIE    = 3;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [2:0] DBG_CAUSE_SWBP = 3'd1;
    localparam int         CODE_BREAK     = 3;

    typedef enum logic [1:0] {
        TGT_MACH      = 2'd0,
        TGT_SUP       = 2'd1,
        TGT_DBG_ENTER = 2'd2,
        TGT_DBG_EXC   = 2'd3
    } target_e;

    typedef struct packed {
        logic pc;
        logic priv;
        logic status;
        logic scause;
        logic sepc;
        logic sbad;
        logic mcause;
        logic mepc;
        logic mbad;
        logic dbg;
        logic dpc;
        logic resv;
    } strobe_t;

    // Status word after trap entry into supervisor (to_m=0) or machine (to_m=1).
    function automatic logic [ST_W-1:0] enter_status(input logic [ST_W-1:0] st,
                                                     input logic [1:0]      prv,
                                                     input logic            to_m);
        logic [ST_W-1:0] s;
        s = st;
        if (to_m) begin
            s[ST_MPIE]                 = st[prv];
            s[ST_MPP_LO+1:ST_MPP_LO]   = prv;
            s[ST_MIE]                  = 1'b0;
        end else begin
            s[ST_SPIE]                 = st[prv];
            s[ST_SPP]                  = prv[0];
            s[ST_SIE]                  = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cause,
    input  logic [1:0]      priv,
    input  logic [XLEN-1:0] medeleg,
    input  logic [XLEN-1:0] mideleg,
    input  logic [2:0]      dbg_cause_in,
    input  logic [3:0]      ebreak_en,
    output target_e         target
);
    localparam int IDX_W = $clog2(XLEN);

    logic              is_int;
    logic [XLEN-2:0]   code;
    logic [XLEN-1:0]   deleg_vec;
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic              is_break;
    logic              delegated;

    always_comb begin
        is_int    = cause[XLEN-1];
        code      = cause[XLEN-2:0];
        deleg_vec = is_int ? mideleg : medeleg;
        idx       = code[IDX_W-1:0];
        in_range  = ((code >> IDX_W) == '0);
        is_break  = !is_int && (code == (XLEN-1)'(CODE_BREAK));
        delegated = (priv <= PRIV_S) && in_range && deleg_vec[idx];

        if (is_break && ebreak_en[priv])
            target = TGT_DBG_ENTER;
        else if (dbg_cause_in != 3'd0)
            target = TGT_DBG_EXC;
        else if (delegated)
            target = TGT_SUP;
        else
            target = TGT_MACH;
    end

endmodule

// File: rtl/trap_update.sv
module trap_update
    import trap_pkg::*;
#(
    parameter int              XLEN          = 32,
    parameter logic [XLEN-1:0] DBG_ROM_START = 'h800,
    parameter logic [XLEN-1:0] DBG_ROM_EXC   = 'h808
) (
    input  target_e         target,
    input  logic [1:0]      priv,
    input  logic            has_addr,
    input  logic [XLEN-1:0] stvec,
    input  logic [XLEN-1:0] mtvec,
    input  logic [ST_W-1:0] status_in,
    output strobe_t         strobes,
    output logic [XLEN-1:0] pc_next,
    output logic [1:0]      priv_next,
    output logic [ST_W-1:0] status_next
);

    always_comb begin
        strobes     = '0;
        pc_next     = mtvec;
        priv_next   = PRIV_M;
        status_next = status_in;
        unique case (target)
            TGT_SUP: begin
                strobes.pc     = 1'b1;
                strobes.priv   = 1'b1;
                strobes.status = 1'b1;
                strobes.scause = 1'b1;
                strobes.sepc   = 1'b1;
                strobes.sbad   = has_addr;
                strobes.resv   = 1'b1;
                pc_next        = stvec;
                priv_next      = PRIV_S;
                status_next    = enter_status(status_in, priv, 1'b0);
            end
            TGT_MACH: begin
                strobes.pc     = 1'b1;
                strobes.priv   = 1'b1;
                strobes.status = 1'b1;
                strobes.mcause = 1'b1;
                strobes.mepc   = 1'b1;
                strobes.mbad   = has_addr;
                strobes.resv   = 1'b1;
                pc_next        = mtvec;
                priv_next      = PRIV_M;
                status_next    = enter_status(status_in, priv, 1'b1);
            end
            TGT_DBG_ENTER: begin
                strobes.pc     = 1'b1;
                strobes.priv   = 1'b1;
                strobes.dbg    = 1'b1;
                strobes.dpc    = 1'b1;
                pc_next        = DBG_ROM_START;
                priv_next      = PRIV_M;
            end
            default: begin
                strobes.pc     = 1'b1;
                pc_next        = DBG_ROM_EXC;
            end
        endcase
    end

endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
#(
    parameter int              XLEN          = 32,
    parameter logic [XLEN-1:0] DBG_ROM_START = 'h800,
    parameter logic [XLEN-1:0] DBG_ROM_EXC   = 'h808
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_valid,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [XLEN-1:0] trap_badaddr,
    input  logic            trap_has_addr,
    input  logic [1:0]      cur_priv,
    input  logic [XLEN-1:0] medeleg,
    input  logic [XLEN-1:0] mideleg,
    input  logic [XLEN-1:0] stvec,
    input  logic [XLEN-1:0] mtvec,
    input  logic [12:0]     status_in,
    input  logic [2:0]      dbg_cause_in,
    input  logic [3:0]      ebreak_en,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_next,
    output logic            priv_we,
    output logic [1:0]      priv_next,
    output logic            status_we,
    output logic [12:0]     status_next,
    output logic            scause_we,
    output logic            sepc_we,
    output logic            sbad_we,
    output logic            mcause_we,
    output logic            mepc_we,
    output logic            mbad_we,
    output logic [XLEN-1:0] cause_next,
    output logic [XLEN-1:0] epc_next,
    output logic [XLEN-1:0] bad_next,
    output logic            dbg_we,
    output logic [2:0]      dbg_cause_next,
    output logic [1:0]      dbg_prv_next,
    output logic            dpc_we,
    output logic            resv_clear
);

    target_e         target;
    strobe_t         strb_c;
    strobe_t         strb_q;
    logic [XLEN-1:0] pc_c;
    logic [1:0]      priv_c;
    logic [ST_W-1:0] status_c;

    trap_route #(.XLEN(XLEN)) i_route (
        .cause        (trap_cause),
        .priv         (cur_priv),
        .medeleg      (medeleg),
        .mideleg      (mideleg),
        .dbg_cause_in (dbg_cause_in),
        .ebreak_en    (ebreak_en),
        .target       (target)
    );

    trap_update #(
        .XLEN          (XLEN),
        .DBG_ROM_START (DBG_ROM_START),
        .DBG_ROM_EXC   (DBG_ROM_EXC)
    ) i_update (
        .target      (target),
        .priv        (cur_priv),
        .has_addr    (trap_has_addr),
        .stvec       (stvec),
        .mtvec       (mtvec),
        .status_in   (status_in),
        .strobes     (strb_c),
        .pc_next     (pc_c),
        .priv_next   (priv_c),
        .status_next (status_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_q         <= '0;
            pc_next        <= '0;
            priv_next      <= PRIV_M;
            status_next    <= '0;
            cause_next     <= '0;
            epc_next       <= '0;
            bad_next       <= '0;
            dbg_cause_next <= '0;
            dbg_prv_next   <= PRIV_U;
        end else begin
            strb_q <= trap_valid ? strb_c : '0;
            if (trap_valid) begin
                pc_next        <= pc_c;
                priv_next      <= priv_c;
                status_next    <= status_c;
                cause_next     <= trap_cause;
                epc_next       <= trap_pc;
                bad_next       <= trap_badaddr;
                dbg_cause_next <= DBG_CAUSE_SWBP;
                dbg_prv_next   <= cur_priv;
            end
        end
    end

    assign pc_we      = strb_q.pc;
    assign priv_we    = strb_q.priv;
    assign status_we  = strb_q.status;
    assign scause_we  = strb_q.scause;
    assign sepc_we    = strb_q.sepc;
    assign sbad_we    = strb_q.sbad;
    assign mcause_we  = strb_q.mcause;
    assign mepc_we    = strb_q.mepc;
    assign mbad_we    = strb_q.mbad;
    assign dbg_we     = strb_q.dbg;
    assign dpc_we     = strb_q.dpc;
    assign resv_clear = strb_q.resv;

endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            trap_valid,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] stvec,
    input logic [XLEN-1:0] mtvec,
    input logic            pc_we,
    input logic [XLEN-1:0] pc_next,
    input logic [1:0]      priv_next,
    input logic [12:0]     status_next,
    input logic            scause_we,
    input logic            mcause_we,
    input logic            dbg_we,
    input logic [2:0]      dbg_cause_next,
    input logic            resv_clear
);

    p_commit_r1: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> pc_we);

    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |=> !pc_we);

    p_one_target_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({scause_we, mcause_we, dbg_we}));

    p_sup_low_priv_r3: assert property (@(posedge clk) disable iff (rst)
        trap_valid && cur_priv > 2'd1 |=> !scause_we);

    p_sup_vector_r4: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> (scause_we -> (pc_next == $past(stvec) && priv_next == 2'd1)));

    p_sup_sie_clear_r5: assert property (@(posedge clk) disable iff (rst)
        scause_we |-> !status_next[1]);

    p_mach_entry_r6: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> (mcause_we -> (pc_next == $past(mtvec) && priv_next == 2'd3 && !status_next[3])));

    p_dbg_entry_r8: assert property (@(posedge clk) disable iff (rst)
        dbg_we |-> (priv_next == 2'd3 && dbg_cause_next == 3'd1));

    p_resv_r10: assert property (@(posedge clk) disable iff (rst)
        resv_clear |-> (scause_we || mcause_we));

endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_trap_unit.sv
module test_trap_unit;

    localparam int XLEN = 32;
    localparam logic [31:0] STVEC_V = 32'h0000_0100;
    localparam logic [31:0] MTVEC_V = 32'h0000_0200;
    localparam logic [31:0] DSTART  = 32'h0000_0800;
    localparam logic [31:0] DEXC    = 32'h0000_0808;
    localparam logic [31:0] MEDELEG_V = 32'h0000_010A; // bits 1,3,8
    localparam logic [31:0] MIDELEG_V = 32'h0000_0022; // bits 1,5
    localparam logic [1:0] K_M = 2'd0, K_S = 2'd1, K_DBG = 2'd2, K_DEXC = 2'd3;

    // {int, code[5:0], prv[1:0], ebreak_en[3:0], dbg_active, has_addr, ie[3:0], kind[1:0]}
    localparam int NV = 16;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 6'd8,  2'd0, 4'b0000, 1'b0, 1'b0, 4'b1111, K_S},
        {1'b0, 6'd8,  2'd1, 4'b0000, 1'b0, 1'b1, 4'b0010, K_S},
        {1'b0, 6'd8,  2'd3, 4'b0000, 1'b0, 1'b1, 4'b1000, K_M},
        {1'b0, 6'd2,  2'd0, 4'b0000, 1'b0, 1'b1, 4'b0001, K_M},
        {1'b1, 6'd1,  2'd0, 4'b0000, 1'b0, 1'b0, 4'b0001, K_S},
        {1'b1, 6'd8,  2'd0, 4'b0000, 1'b0, 1'b0, 4'b0000, K_M},
        {1'b0, 6'd5,  2'd1, 4'b0000, 1'b0, 1'b1, 4'b0010, K_M},
        {1'b1, 6'd5,  2'd1, 4'b0000, 1'b0, 1'b0, 4'b0010, K_S},
        {1'b0, 6'd3,  2'd1, 4'b0010, 1'b0, 1'b1, 4'b0110, K_DBG},
        {1'b0, 6'd3,  2'd0, 4'b0010, 1'b0, 1'b0, 4'b0001, K_S},
        {1'b0, 6'd3,  2'd3, 4'b1000, 1'b0, 1'b0, 4'b1000, K_DBG},
        {1'b0, 6'd2,  2'd0, 4'b0000, 1'b1, 1'b1, 4'b0001, K_DEXC},
        {1'b0, 6'd3,  2'd1, 4'b0010, 1'b1, 1'b0, 4'b0010, K_DBG},
        {1'b1, 6'd3,  2'd3, 4'b1000, 1'b0, 1'b0, 4'b1000, K_M},
        {1'b0, 6'd33, 2'd0, 4'b0000, 1'b0, 1'b1, 4'b0001, K_M},
        {1'b0, 6'd8,  2'd2, 4'b0000, 1'b0, 1'b0, 4'b0100, K_M}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic            trap_valid = 1'b0;
    logic [31:0]     trap_cause = '0, trap_pc = '0, trap_badaddr = '0;
    logic            trap_has_addr = 1'b0;
    logic [1:0]      cur_priv = 2'd0;
    logic [31:0]     medeleg = MEDELEG_V, mideleg = MIDELEG_V;
    logic [31:0]     stvec = STVEC_V, mtvec = MTVEC_V;
    logic [12:0]     status_in = '0;
    logic [2:0]      dbg_cause_in = '0;
    logic [3:0]      ebreak_en = '0;
    logic            pc_we, priv_we, status_we, scause_we, sepc_we, sbad_we;
    logic            mcause_we, mepc_we, mbad_we, dbg_we, dpc_we, resv_clear;
    logic [31:0]     pc_next, cause_next, epc_next, bad_next;
    logic [1:0]      priv_next, dbg_prv_next;
    logic [12:0]     status_next;
    logic [2:0]      dbg_cause_next;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    trap_unit #(.XLEN(XLEN), .DBG_ROM_START(DSTART), .DBG_ROM_EXC(DEXC)) i_trap_unit (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_pc(trap_pc), .trap_badaddr(trap_badaddr), .trap_has_addr(trap_has_addr),
        .cur_priv(cur_priv), .medeleg(medeleg), .mideleg(mideleg), .stvec(stvec),
        .mtvec(mtvec), .status_in(status_in), .dbg_cause_in(dbg_cause_in),
        .ebreak_en(ebreak_en), .pc_we(pc_we), .pc_next(pc_next), .priv_we(priv_we),
        .priv_next(priv_next), .status_we(status_we), .status_next(status_next),
        .scause_we(scause_we), .sepc_we(sepc_we), .sbad_we(sbad_we),
        .mcause_we(mcause_we), .mepc_we(mepc_we), .mbad_we(mbad_we),
        .cause_next(cause_next), .epc_next(epc_next), .bad_next(bad_next),
        .dbg_we(dbg_we), .dbg_cause_next(dbg_cause_next), .dbg_prv_next(dbg_prv_next),
        .dpc_we(dpc_we), .resv_clear(resv_clear)
    );

    function automatic logic [11:0] strobes_now();
        return {pc_we, priv_we, status_we, scause_we, sepc_we, sbad_we,
                mcause_we, mepc_we, mbad_we, dbg_we, dpc_we, resv_clear};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [12:0] exp_status(input logic [12:0] st, input logic [1:0] prv,
                                               input logic [1:0] kind);
        logic [12:0] s;
        s = st;
        if (kind == K_S) begin
            s[5] = st[prv]; s[8] = prv[0]; s[1] = 1'b0;
        end else begin
            s[7] = st[prv]; s[12:11] = prv; s[3] = 1'b0;
        end
        return s;
    endfunction

    task automatic run_vec(input int i);
        logic [20:0] v;
        logic [1:0]  kind, prv;
        logic        ha;
        logic [11:0] es;
        logic [12:0] st;
        v    = VEC[i];
        kind = v[1:0];
        prv  = v[13:12];
        ha   = v[6];
        st   = {2'b10, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, v[5:2]};
        @(negedge clk);
        trap_valid    = 1'b1;
        trap_cause    = {v[20], 25'd0, v[19:14]};
        trap_pc       = 32'h0000_1000 + 32'(i * 4);
        trap_badaddr  = 32'hBAD0_0000 + 32'(i);
        trap_has_addr = ha;
        cur_priv      = prv;
        ebreak_en     = v[11:8];
        dbg_cause_in  = v[7] ? 3'd2 : 3'd0;
        status_in     = st;
        @(negedge clk);
        trap_valid = 1'b0;
        case (kind)
            K_M:     es = {1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0, 1'b1,1'b1,ha, 1'b0,1'b0,1'b1};
            K_S:     es = {1'b1,1'b1,1'b1, 1'b1,1'b1,ha, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1};
            K_DBG:   es = {1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0};
            default: es = 12'b1000_0000_0000;
        endcase
        // Strobe pattern: target choice R2/R3, bad address R7, reservation R10
        check($sformatf("R3 R7 R10 strobes vec%0d", i), 32'(strobes_now()), 32'(es));
        case (kind)
            K_S: begin
                check($sformatf("R4 pc vec%0d", i), pc_next, STVEC_V);
                check($sformatf("R4 priv vec%0d", i), 32'(priv_next), 32'd1);
                check($sformatf("R4 cause vec%0d", i), cause_next, trap_cause);
                check($sformatf("R4 epc vec%0d", i), epc_next, trap_pc);
                check($sformatf("R5 status vec%0d", i), 32'(status_next), 32'(exp_status(st, prv, K_S)));
            end
            K_M: begin
                check($sformatf("R6 pc vec%0d", i), pc_next, MTVEC_V);
                check($sformatf("R6 priv vec%0d", i), 32'(priv_next), 32'd3);
                check($sformatf("R6 cause vec%0d", i), cause_next, trap_cause);
                check($sformatf("R6 epc vec%0d", i), epc_next, trap_pc);
                check($sformatf("R6 status vec%0d", i), 32'(status_next), 32'(exp_status(st, prv, K_M)));
            end
            K_DBG: begin
                check($sformatf("R8 pc vec%0d", i), pc_next, DSTART);
                check($sformatf("R8 priv vec%0d", i), 32'(priv_next), 32'd3);
                check($sformatf("R8 dcause vec%0d", i), 32'(dbg_cause_next), 32'd1);
                check($sformatf("R8 dprv vec%0d", i), 32'(dbg_prv_next), 32'(prv));
                check($sformatf("R8 dpc vec%0d", i), epc_next, trap_pc);
            end
            default: check($sformatf("R9 pc vec%0d", i), pc_next, DEXC);
        endcase
        if (ha && (kind == K_S || kind == K_M))
            check($sformatf("R7 bad vec%0d", i), bad_next, trap_badaddr);
        @(negedge clk);
        check($sformatf("R1 strobes drop vec%0d", i), 32'(strobes_now()), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        trap_valid = 1'b1;
        @(negedge clk);
        check("R1 reset strobes", 32'(strobes_now()), 32'd0);
        trap_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle strobes", 32'(strobes_now()), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // Back-to-back traps: each cycle commits its own result (R1, R2)
        @(negedge clk);
        trap_valid = 1'b1; trap_cause = 32'h8000_0001; cur_priv = 2'd0;
        dbg_cause_in = 3'd0; ebreak_en = 4'b0000; trap_has_addr = 1'b0;
        @(negedge clk);
        trap_cause = 32'h0000_0001; cur_priv = 2'd1;
        check("R2 b2b first to S", 32'(scause_we), 32'd1);
        @(negedge clk);
        trap_valid = 1'b0;
        check("R2 b2b second exc bit1 to S", 32'(scause_we), 32'd1);
        check("R1 b2b pc_we", 32'(pc_we), 32'd1);
        // Clearing the exception mask sends the same exception to machine mode (R2)
        medeleg = 32'h0;
        @(negedge clk);
        trap_valid = 1'b1;
        @(negedge clk);
        trap_valid = 1'b0;
        check("R2 exc mask cleared to M", 32'(mcause_we), 32'd1);
        check("R2 exc mask cleared no S", 32'(scause_we), 32'd0);
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule